// File: doc/BRIEF.md
# Command-Encoded ALU with Condition Flags

This block is the arithmetic and logic core of a simple 32-bit execution stage. It is purely combinational. From two operands, a 4-bit operation code supplied by the control unit and the four condition flags currently held in a separate status register, it returns a 32-bit result and the four flags that operation would produce. The flags are outputs only; the surrounding pipeline decides whether to store them.

It covers move, inverted move, add, add with carry, subtract, subtract with carry (which subtracts the inverse of the carry flag), and bitwise AND, OR and XOR. Compare and test reuse the subtract and AND codes; address generation for loads and stores reuses the add code. Operand selection, shifting and writeback belong to other blocks. Codes that name no operation give a zero result and hand all four incoming flags back untouched.

Top module: `flagged_alu`

## Requirements
- R1: Code 4'b0001 (move) returns operand B unchanged as the result.
- R2: Code 4'b1001 (inverted move) returns the bitwise inverse of operand B.
- R3: Code 4'b0010 returns A + B modulo 2^32; code 4'b0011 returns A + B + C, where C is flags_in[1].
- R4: Code 4'b0100 returns A - B modulo 2^32; code 4'b0101 returns A - B - (1 - C), where C is flags_in[1].
- R5: Code 4'b0110 returns A AND B, code 4'b0111 returns A OR B, code 4'b1000 returns A XOR B.
- R6: For every defined code, flags_out[3] (negative) equals result bit 31 and flags_out[2] (zero) is set exactly when the result is all zeros.
- R7: flags_out[1] (carry) is the carry out of bit 31 for codes 4'b0010 and 4'b0011, and for codes 4'b0100 and 4'b0101 it is set exactly when the subtraction needs no borrow (unsigned A is at least B plus the borrow-in).
- R8: flags_out[0] (overflow) is set for the four arithmetic codes exactly when the true signed (two's complement) outcome does not fit in 32 bits.
- R9: For the move, inverted move, AND, OR and XOR codes, flags_out[1] and flags_out[0] equal flags_in[1] and flags_in[0].
- R10: Codes 4'b0000 and 4'b1010 through 4'b1111 give a zero result and flags_out equal to flags_in.
- R11: Codes 4'b0010 and 4'b0100 ignore the incoming carry: their result and flags are the same for either value of flags_in[1].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand (A) |
| opnd_b | input | 32 | Second operand (B) |
| alu_cmd | input | 4 | Operation code from the control unit |
| flags_in | input | 4 | Current flags: [3] negative, [2] zero, [1] carry, [0] overflow |
| result_out | output | 32 | Operation result |
| flags_out | output | 4 | Flags the operation produces, same bit order as flags_in |

## Verification
The result path and the flag path answer for the same operation at once, so a zero result can coincide with a carry out (all-ones plus one), and a negative result can coincide with a signed overflow (largest positive plus one). The bench provokes these by crossing every code and every incoming flag pattern with a set of edge operands (zero, one, the signed extremes, all ones) plus pseudo-random words, and judges result and each flag group as separate checks against signed and unsigned wide arithmetic computed in the bench, so a wrong carry cannot hide behind a right sum.

// File: rtl/flagged_alu_pkg.sv
`timescale 1ns/1ps
package flagged_alu_pkg;

  typedef enum logic [3:0] {
    OP_PASS_B = 4'b0001,
    OP_ADD    = 4'b0010,
    OP_ADD_C  = 4'b0011,
    OP_SUB    = 4'b0100,
    OP_SUB_C  = 4'b0101,
    OP_AND    = 4'b0110,
    OP_OR     = 4'b0111,
    OP_XOR    = 4'b1000,
    OP_NOT_B  = 4'b1001
  } alu_op_e;

  localparam int FLG_NEG = 3;
  localparam int FLG_ZER = 2;
  localparam int FLG_CRY = 1;
  localparam int FLG_OVF = 0;

  function automatic logic op_is_arith(input logic [3:0] op);
    return (op == OP_ADD) || (op == OP_ADD_C) || (op == OP_SUB) || (op == OP_SUB_C);
  endfunction

  function automatic logic op_is_logic(input logic [3:0] op);
    return (op == OP_PASS_B) || (op == OP_NOT_B) || (op == OP_AND) ||
           (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic op_is_sub(input logic [3:0] op);
    return (op == OP_SUB) || (op == OP_SUB_C);
  endfunction

  // carry injected at bit 0 of the shared adder
  function automatic logic op_carry_seed(input logic [3:0] op, input logic cur_c);
    logic seed;
    case (op)
      OP_ADD_C: seed = cur_c;
      OP_SUB:   seed = 1'b1;
      OP_SUB_C: seed = cur_c;
      default:  seed = 1'b0;
    endcase
    return seed;
  endfunction

  // signed overflow from the sign bits of the adder inputs and sum
  function automatic logic sign_overflow(input logic x_msb, input logic y_msb,
                                         input logic s_msb);
    return (x_msb == y_msb) && (s_msb != x_msb);
  endfunction

endpackage

// File: rtl/alu_arith_unit.sv
`timescale 1ns/1ps
module alu_arith_unit
  import flagged_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  input  logic         cur_c_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int WX = W + 1;

  logic [W-1:0]  b_eff;
  logic          seed;
  logic [WX-1:0] wide_sum;

  always_comb begin
    b_eff    = op_is_sub(op_i) ? ~b_i : b_i;
    seed     = op_carry_seed(op_i, cur_c_i);
    wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, seed};
  end

  assign sum_o  = wide_sum[W-1:0];
  assign cout_o = wide_sum[W];
  assign ovf_o  = sign_overflow(a_i[W-1], b_eff[W-1], wide_sum[W-1]);
endmodule

// File: rtl/alu_logic_unit.sv
`timescale 1ns/1ps
module alu_logic_unit
  import flagged_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_PASS_B: res_o = b_i;
      OP_NOT_B:  res_o = ~b_i;
      OP_AND:    res_o = a_i & b_i;
      OP_OR:     res_o = a_i | b_i;
      OP_XOR:    res_o = a_i ^ b_i;
      default:   res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_unit.sv
`timescale 1ns/1ps
module alu_flag_unit
  import flagged_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic         valid_i,
  input  logic         arith_i,
  input  logic         cout_i,
  input  logic         ovf_i,
  input  logic [3:0]   flags_i,
  output logic [3:0]   flags_o
);
  always_comb begin
    flags_o = flags_i;
    if (valid_i) begin
      flags_o[FLG_NEG] = res_i[W-1];
      flags_o[FLG_ZER] = ~|res_i;
      if (arith_i) begin
        flags_o[FLG_CRY] = cout_i;
        flags_o[FLG_OVF] = ovf_i;
      end
    end
  end
endmodule

// File: rtl/flagged_alu.sv
`timescale 1ns/1ps
module flagged_alu
  import flagged_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [3:0]   alu_cmd,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] result_out,
  output logic [3:0]   flags_out
);
  // named internal events, visible to the bound checker
  logic         arith_sel;
  logic         logic_sel;
  logic         cmd_valid;
  logic [W-1:0] arith_sum;
  logic         arith_cout;
  logic         arith_ovf;
  logic [W-1:0] logic_res;

  assign arith_sel = op_is_arith(alu_cmd);
  assign logic_sel = op_is_logic(alu_cmd);
  assign cmd_valid = arith_sel | logic_sel;

  alu_arith_unit #(.W(W)) u_arith (
    .a_i     (opnd_a),
    .b_i     (opnd_b),
    .op_i    (alu_cmd),
    .cur_c_i (flags_in[FLG_CRY]),
    .sum_o   (arith_sum),
    .cout_o  (arith_cout),
    .ovf_o   (arith_ovf)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .op_i  (alu_cmd),
    .res_o (logic_res)
  );

  always_comb begin
    if (arith_sel)      result_out = arith_sum;
    else if (logic_sel) result_out = logic_res;
    else                result_out = '0;
  end

  alu_flag_unit #(.W(W)) u_flags (
    .res_i   (result_out),
    .valid_i (cmd_valid),
    .arith_i (arith_sel),
    .cout_i  (arith_cout),
    .ovf_i   (arith_ovf),
    .flags_i (flags_in),
    .flags_o (flags_out)
  );
endmodule

// File: rtl/flagged_alu_chk.sv
`timescale 1ns/1ps
module flagged_alu_chk
  import flagged_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [3:0]   alu_cmd,
  input logic [3:0]   flags_in,
  input logic [W-1:0] result_out,
  input logic [3:0]   flags_out,
  input logic         cmd_valid,
  input logic         logic_sel
);
  always_comb begin
    // R10
    if (!cmd_valid) unused_cmd_chk: assert (result_out == '0 && flags_out == flags_in);
    // R9
    if (logic_sel) logic_cv_keep_chk: assert (flags_out[1:0] == flags_in[1:0]);
    // R6
    if (cmd_valid) neg_flag_chk: assert (flags_out[FLG_NEG] == result_out[W-1]);
    // R6
    if (cmd_valid) zero_flag_chk: assert (flags_out[FLG_ZER] == (result_out == '0));
    // R1
    if (alu_cmd == OP_PASS_B) pass_b_chk: assert (result_out == opnd_b);
    // R7
    if (alu_cmd == OP_ADD) add_carry_chk:
      assert ({flags_out[FLG_CRY], result_out} == ({1'b0, opnd_a} + {1'b0, opnd_b}));
    // R7
    if (alu_cmd == OP_SUB) sub_noborrow_chk: assert (flags_out[FLG_CRY] == (opnd_a >= opnd_b));
    // R8
    if (alu_cmd == OP_ADD) add_overflow_chk:
      assert (flags_out[FLG_OVF] ==
              ((opnd_a[W-1] == opnd_b[W-1]) && (result_out[W-1] != opnd_a[W-1])));
  end
endmodule

bind flagged_alu flagged_alu_chk #(.W(W)) u_flagged_alu_chk (
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b),
  .alu_cmd    (alu_cmd),
  .flags_in   (flags_in),
  .result_out (result_out),
  .flags_out  (flags_out),
  .cmd_valid  (cmd_valid),
  .logic_sel  (logic_sel)
);

// File: tb/flagged_alu_bench.sv
`timescale 1ns/1ps
module flagged_alu_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [3:0]  alu_cmd = '0;
  logic [3:0]  flags_in = '0;
  logic [31:0] result_out;
  logic [3:0]  flags_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  flagged_alu u_flagged_alu (
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .alu_cmd    (alu_cmd),
    .flags_in   (flags_in),
    .result_out (result_out),
    .flags_out  (flags_out)
  );

  function automatic string res_tag(input logic [3:0] c);
    case (c)
      4'b0001: return "R1";
      4'b1001: return "R2";
      4'b0010: return "R3 R11";
      4'b0011: return "R3";
      4'b0100: return "R4 R11";
      4'b0101: return "R4";
      4'b0110, 4'b0111, 4'b1000: return "R5";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] edge_val(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      5: return 32'h8000_0001;
      6: return 32'h5555_AAAA;
      default: return 32'hFFFF_FFFE;
    endcase
  endfunction

  task automatic check_one(input logic [31:0] a, input logic [31:0] b,
                           input logic [3:0] c, input logic [3:0] fin);
    logic [31:0] er;
    logic        en, ez, ec, ev;
    longint      sa, sb, sres;
    longint unsigned ua, ub, wide;
    logic        cin;
    int          bor;
    bit          arith, defined;
    ua = {32'h0, a}; ub = {32'h0, b};
    sa = longint'($signed(a)); sb = longint'($signed(b));
    cin = fin[1];
    arith = 1'b0; defined = 1'b1;
    ec = fin[1]; ev = fin[0];
    er = '0;
    case (c)
      4'b0001: er = b;
      4'b1001: er = ~b;
      4'b0110: er = a & b;
      4'b0111: er = a | b;
      4'b1000: er = a ^ b;
      4'b0010, 4'b0011: begin
        arith = 1'b1;
        bor = (c == 4'b0011 && cin) ? 1 : 0;
        wide = ua + ub + longint'(bor);
        er = wide[31:0];
        ec = wide[32];
        sres = sa + sb + longint'(bor);
        ev = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
      end
      4'b0100, 4'b0101: begin
        arith = 1'b1;
        bor = (c == 4'b0101 && !cin) ? 1 : 0;
        er = a - b - 32'(bor);
        ec = (ua >= ub + longint'(bor));
        sres = sa - sb - longint'(bor);
        ev = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
      end
      default: defined = 1'b0;
    endcase
    en = defined ? er[31] : fin[3];
    ez = defined ? (er == 32'h0) : fin[2];

    opnd_a = a; opnd_b = b; alu_cmd = c; flags_in = fin;
    #2;
    checks++;
    if (result_out !== er) begin
      errors++;
      $display("FAIL %s cmd=%b a=%h b=%h fin=%b result actual=%h expected=%h",
               res_tag(c), c, a, b, fin, result_out, er);
    end
    checks++;
    if (flags_out[3:2] !== {en, ez}) begin
      errors++;
      $display("FAIL %s cmd=%b a=%h b=%h fin=%b NZ actual=%b expected=%b",
               defined ? "R6" : "R10", c, a, b, fin, flags_out[3:2], {en, ez});
    end
    checks++;
    if (flags_out[1] !== ec) begin
      errors++;
      $display("FAIL %s cmd=%b a=%h b=%h fin=%b C actual=%b expected=%b",
               arith ? "R7" : (defined ? "R9" : "R10"), c, a, b, fin, flags_out[1], ec);
    end
    checks++;
    if (flags_out[0] !== ev) begin
      errors++;
      $display("FAIL %s cmd=%b a=%h b=%h fin=%b V actual=%b expected=%b",
               arith ? "R8" : (defined ? "R9" : "R10"), c, a, b, fin, flags_out[0], ev);
    end
  endtask

  // R11: carry-independent codes give identical outputs for either carry input
  task automatic check_carry_blind(input logic [31:0] a, input logic [31:0] b,
                                   input logic [3:0] c);
    logic [31:0] r0;
    logic [1:0]  f0;
    opnd_a = a; opnd_b = b; alu_cmd = c; flags_in = 4'b0000;
    #2;
    r0 = result_out; f0 = flags_out[1:0];
    flags_in = 4'b0010;
    #2;
    checks++;
    if (result_out !== r0 || flags_out[1:0] !== f0) begin
      errors++;
      $display("FAIL R11 cmd=%b a=%h b=%h actual=%h/%b expected=%h/%b",
               c, a, b, result_out, flags_out[1:0], r0, f0);
    end
  endtask

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset-state check: idle inputs give zero result and quiet flags (R10)
    checks++;
    if (result_out !== 32'h0 || flags_out !== 4'h0) begin
      errors++;
      $display("FAIL R10 idle actual=%h/%b expected=%h/%b", result_out, flags_out,
               32'h0, 4'h0);
    end
    // sweep: every code x every flag pattern x edge operand pairs
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        for (int i = 0; i < 8; i++) begin
          for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            check_one(edge_val(i), edge_val(j), 4'(c), 4'(f));
          end
        end
      end
    end
    // pseudo-random words across all codes
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] ra, rb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rb = lfsr ^ 32'h9E37_79B9;
      @(negedge clk);
      check_one(ra, rb, 4'(k % 16), 4'((k * 7) % 16));
    end
    // R11 focused checks
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check_carry_blind(edge_val(i), edge_val(7 - i), 4'b0010);
      @(negedge clk);
      check_carry_blind(edge_val(i), edge_val(7 - i), 4'b0100);
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired before the sweep completed");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule